// File: doc/BRIEF.md
# Execute Stage with ALU Operation Decode

This block is the execute step of a five-step in-order pipeline. It takes the operands, immediate, next-PC value, register-field numbers and control bits that the decode step has latched, and produces the arithmetic result, a zero indication and a branch target address. All of these, together with the forwarded memory and write-back control, are captured in a single pipeline register.

A small decoder turns the 2-bit operation class and the 6-bit function field of the instruction into a 3-bit ALU select. The ALU adds, subtracts, ANDs, ORs or compares (signed less-than). A separate adder forms the branch target as the next PC plus the sign-extended offset. The offset is used as a byte offset and is not shifted. Two selectors pick the ALU's second operand and the destination register number.

An operation class and function field pair that names no supported instruction gives no defined result. Such an entry is marked by an invalid flag in the pipeline register.

Top module: `exec_stage`

## Requirements
- R1: With operation class 2'b00 the result is operand A plus operand B. With class 2'b01 it is A minus B. In both cases the function field has no effect.
- R2: With operation class 2'b10 the function field picks the operation: 6'b100000 add, 6'b100010 subtract, 6'b100100 bitwise AND, 6'b100101 bitwise OR, 6'b101010 set-less-than.
- R3: Operation class 2'b11, or class 2'b10 with any other function value, sets `op_invalid_q` to 1 and leaves the result undefined. Every valid operation sets it to 0.
- R4: Set-less-than compares A and B as signed 32-bit numbers. It returns 1 or 0 in bit 0, and bits 31:1 are zero.
- R5: For a valid operation, `zero_q` is 1 exactly when the 32-bit result is zero.
- R6: When `alu_src_in` is 1, operand B is `imm_ext`. When it is 0, operand B is `rd_val_b`.
- R7: `br_target_q` equals `next_pc_in + imm_ext`, modulo 2^32, with no shift of the offset.
- R8: `dest_reg_q` is `rt_field` when `reg_dst_in` is 0 and `rd_field` when it is 1.
- R9: All outputs are registered and reflect the inputs present at the previous rising clock edge. `wb_ctl_q`, `mem_ctl_q` and `store_val_q` are unchanged copies of `wb_ctl_in`, `mem_ctl_in` and `rd_val_b`.
- R10: A synchronous active-high `rst` clears every output to zero, except `zero_q`, which reads 1 so that it agrees with the cleared result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wb_ctl_in | input | 2 | Write-back control bits to forward |
| mem_ctl_in | input | 3 | Memory control bits to forward |
| alu_op_in | input | 2 | Operation class |
| alu_src_in | input | 1 | Operand B select: 1 immediate, 0 register |
| reg_dst_in | input | 1 | Destination select: 1 rd field, 0 rt field |
| funct_in | input | 6 | Instruction function field |
| next_pc_in | input | 32 | Address of the following instruction |
| rd_val_a | input | 32 | First register read value (operand A) |
| rd_val_b | input | 32 | Second register read value |
| imm_ext | input | 32 | Sign-extended immediate / branch offset |
| rt_field | input | 5 | Instruction bits 20:16 |
| rd_field | input | 5 | Instruction bits 15:11 |
| wb_ctl_q | output | 2 | Latched write-back control |
| mem_ctl_q | output | 3 | Latched memory control |
| br_target_q | output | 32 | Latched branch target |
| zero_q | output | 1 | Latched zero flag |
| alu_res_q | output | 32 | Latched ALU result |
| store_val_q | output | 32 | Latched second register value |
| dest_reg_q | output | 5 | Latched destination register number |
| op_invalid_q | output | 1 | Latched invalid-operation flag |

## Verification
A branch-style entry uses the subtract path for the zero flag and the target adder for the address in the same cycle. The two must not disturb each other. The bench drives class 2'b01 with equal operands while also applying a negative offset and a nonzero next PC. It also drives the ALU-source immediate path while the offset adder reads the same immediate. Both fields of the one captured entry are then compared against values computed separately in the bench.

// File: rtl/exec_stage_pkg.sv
package exec_stage_pkg;

    localparam int FUNCT_W = 6;

    typedef enum logic [2:0] {
        ALU_AND   = 3'b000,
        ALU_OR    = 3'b001,
        ALU_ADD   = 3'b010,
        ALU_BAD_A = 3'b011,
        ALU_BAD_B = 3'b100,
        ALU_SUB   = 3'b110,
        ALU_SLT   = 3'b111
    } alu_sel_e;

    localparam logic [1:0] AOP_ADD  = 2'b00;
    localparam logic [1:0] AOP_SUB  = 2'b01;
    localparam logic [1:0] AOP_FUNC = 2'b10;

    localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FUNCT_W-1:0] FN_AND = 6'b100100;
    localparam logic [FUNCT_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FUNCT_W-1:0] FN_SLT = 6'b101010;

    function automatic logic sel_is_legal(input alu_sel_e s);
        return (s == ALU_AND) || (s == ALU_OR) || (s == ALU_ADD) ||
               (s == ALU_SUB) || (s == ALU_SLT);
    endfunction

endpackage

// File: rtl/exs_alu_ctrl.sv
module exs_alu_ctrl
    import exec_stage_pkg::*;
(
    input  logic [1:0]         aop,
    input  logic [FUNCT_W-1:0] funct,
    output alu_sel_e           sel
);
    always_comb begin
        case (aop)
            AOP_ADD:  sel = ALU_ADD;
            AOP_SUB:  sel = ALU_SUB;
            AOP_FUNC: begin
                case (funct)
                    FN_ADD:  sel = ALU_ADD;
                    FN_SUB:  sel = ALU_SUB;
                    FN_AND:  sel = ALU_AND;
                    FN_OR:   sel = ALU_OR;
                    FN_SLT:  sel = ALU_SLT;
                    default: sel = ALU_BAD_A;
                endcase
            end
            default:  sel = ALU_BAD_A;
        endcase
    end
endmodule

// File: rtl/exs_alu.sv
module exs_alu
    import exec_stage_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  alu_sel_e          sel,
    output logic [DATA_W-1:0] res,
    output logic              zero,
    output logic              bad
);
    always_comb begin
        bad = 1'b0;
        case (sel)
            ALU_ADD: res = opa + opb;
            ALU_SUB: res = opa - opb;
            ALU_AND: res = opa & opb;
            ALU_OR:  res = opa | opb;
            ALU_SLT: res = {{(DATA_W-1){1'b0}}, ($signed(opa) < $signed(opb))};
            default: begin
                res = 'x;
                bad = 1'b1;
            end
        endcase
        zero = (res == '0);
    end
endmodule

// File: rtl/exs_pipe_reg.sv
module exs_pipe_reg #(
    parameter int          W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= RST_VAL;
        else     q <= d;
    end
endmodule

// File: rtl/exec_stage.sv
module exec_stage
    import exec_stage_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5,
    parameter int WB_W   = 2,
    parameter int MEM_W  = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WB_W-1:0]    wb_ctl_in,
    input  logic [MEM_W-1:0]   mem_ctl_in,
    input  logic [1:0]         alu_op_in,
    input  logic               alu_src_in,
    input  logic               reg_dst_in,
    input  logic [FUNCT_W-1:0] funct_in,
    input  logic [DATA_W-1:0]  next_pc_in,
    input  logic [DATA_W-1:0]  rd_val_a,
    input  logic [DATA_W-1:0]  rd_val_b,
    input  logic [DATA_W-1:0]  imm_ext,
    input  logic [REG_AW-1:0]  rt_field,
    input  logic [REG_AW-1:0]  rd_field,
    output logic [WB_W-1:0]    wb_ctl_q,
    output logic [MEM_W-1:0]   mem_ctl_q,
    output logic [DATA_W-1:0]  br_target_q,
    output logic               zero_q,
    output logic [DATA_W-1:0]  alu_res_q,
    output logic [DATA_W-1:0]  store_val_q,
    output logic [REG_AW-1:0]  dest_reg_q,
    output logic               op_invalid_q
);
    localparam int PAY_W = WB_W + MEM_W + DATA_W + 1 + DATA_W + DATA_W + REG_AW + 1;
    localparam logic [PAY_W-1:0] PAY_RST =
        {{(WB_W + MEM_W + DATA_W){1'b0}}, 1'b1, {(DATA_W + DATA_W + REG_AW + 1){1'b0}}};

    alu_sel_e          dec_sel;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] alu_res;
    logic              alu_zero;
    logic              alu_bad;
    logic [DATA_W-1:0] br_sum;
    logic [REG_AW-1:0] dest_sel;
    logic [PAY_W-1:0]  pay_d;
    logic [PAY_W-1:0]  pay_q;

    exs_alu_ctrl u_ctrl (
        .aop   (alu_op_in),
        .funct (funct_in),
        .sel   (dec_sel)
    );

    assign opnd_b = alu_src_in ? imm_ext : rd_val_b;

    exs_alu #(.DATA_W(DATA_W)) u_alu (
        .opa  (rd_val_a),
        .opb  (opnd_b),
        .sel  (dec_sel),
        .res  (alu_res),
        .zero (alu_zero),
        .bad  (alu_bad)
    );

    assign br_sum   = next_pc_in + imm_ext;
    assign dest_sel = reg_dst_in ? rd_field : rt_field;

    assign pay_d = {wb_ctl_in, mem_ctl_in, br_sum, alu_zero, alu_res,
                    rd_val_b, dest_sel, alu_bad};

    exs_pipe_reg #(.W(PAY_W), .RST_VAL(PAY_RST)) u_exmem (
        .clk (clk),
        .rst (rst),
        .d   (pay_d),
        .q   (pay_q)
    );

    assign {wb_ctl_q, mem_ctl_q, br_target_q, zero_q, alu_res_q,
            store_val_q, dest_reg_q, op_invalid_q} = pay_q;

    // R1
    property p_fixed_class;
        @(posedge clk) disable iff (rst)
            (alu_op_in == AOP_ADD) |-> (dec_sel == ALU_ADD);
    endproperty
    fixed_class_add_chk: assert property (p_fixed_class);

    // R3
    property p_class3_bad;
        @(posedge clk) disable iff (rst)
            (alu_op_in == 2'b11) |=> op_invalid_q;
    endproperty
    class3_invalid_chk: assert property (p_class3_bad);

    // R4
    property p_slt_upper;
        @(posedge clk) disable iff (rst)
            (dec_sel == ALU_SLT) |=> (alu_res_q[DATA_W-1:1] == '0);
    endproperty
    slt_upper_zero_chk: assert property (p_slt_upper);

    // R5
    property p_zero_match;
        @(posedge clk) disable iff (rst)
            !op_invalid_q |-> (zero_q == (alu_res_q == '0));
    endproperty
    zero_flag_chk: assert property (p_zero_match);

    // R8
    property p_dest;
        @(posedge clk) disable iff (rst)
            reg_dst_in |=> (dest_reg_q == $past(rd_field));
    endproperty
    dest_rd_chk: assert property (p_dest);

    // R3
    property p_legal_ok;
        @(posedge clk) disable iff (rst)
            sel_is_legal(dec_sel) |=> !op_invalid_q;
    endproperty
    legal_not_invalid_chk: assert property (p_legal_ok);

endmodule

// File: tb/exec_stage_tb.sv
module exec_stage_tb;

    typedef struct {
        logic [1:0]  wb;
        logic [2:0]  mem;
        logic [31:0] bt;
        logic        zero;
        logic [31:0] res;
        logic [31:0] store;
        logic [4:0]  dest;
        logic        inv;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  wb_ctl_in;
    logic [2:0]  mem_ctl_in;
    logic [1:0]  alu_op_in;
    logic        alu_src_in;
    logic        reg_dst_in;
    logic [5:0]  funct_in;
    logic [31:0] next_pc_in, rd_val_a, rd_val_b, imm_ext;
    logic [4:0]  rt_field, rd_field;
    logic [1:0]  wb_ctl_q;
    logic [2:0]  mem_ctl_q;
    logic [31:0] br_target_q, alu_res_q, store_val_q;
    logic        zero_q, op_invalid_q;
    logic [4:0]  dest_reg_q;

    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 0;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    exec_stage u_dut (
        .clk(clk), .rst(rst), .wb_ctl_in(wb_ctl_in), .mem_ctl_in(mem_ctl_in),
        .alu_op_in(alu_op_in), .alu_src_in(alu_src_in), .reg_dst_in(reg_dst_in),
        .funct_in(funct_in), .next_pc_in(next_pc_in), .rd_val_a(rd_val_a),
        .rd_val_b(rd_val_b), .imm_ext(imm_ext), .rt_field(rt_field),
        .rd_field(rd_field), .wb_ctl_q(wb_ctl_q), .mem_ctl_q(mem_ctl_q),
        .br_target_q(br_target_q), .zero_q(zero_q), .alu_res_q(alu_res_q),
        .store_val_q(store_val_q), .dest_reg_q(dest_reg_q),
        .op_invalid_q(op_invalid_q)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic drive(input string tag, input logic [1:0] op, input logic [5:0] fn,
                         input logic src, input logic dst,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] imm, input logic [31:0] pc,
                         input logic [4:0] rt, input logic [4:0] rd,
                         input logic [1:0] wb, input logic [2:0] mem);
        exp_t e;
        logic [31:0] bb;
        @(negedge clk);
        alu_op_in = op; funct_in = fn; alu_src_in = src; reg_dst_in = dst;
        rd_val_a = a; rd_val_b = b; imm_ext = imm; next_pc_in = pc;
        rt_field = rt; rd_field = rd; wb_ctl_in = wb; mem_ctl_in = mem;
        bb = src ? imm : b;
        e.inv = 1'b0;
        e.res = '0;
        case (op)
            2'b00: e.res = a + bb;
            2'b01: e.res = a - bb;
            2'b10: begin
                case (fn)
                    6'b100000: e.res = a + bb;
                    6'b100010: e.res = a - bb;
                    6'b100100: e.res = a & bb;
                    6'b100101: e.res = a | bb;
                    6'b101010: e.res = ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
                    default:   e.inv = 1'b1;
                endcase
            end
            default: e.inv = 1'b1;
        endcase
        e.zero  = (e.res == 32'd0);
        e.bt    = pc + imm;
        e.dest  = dst ? rd : rt;
        e.store = b;
        e.wb    = wb;
        e.mem   = mem;
        e.tag   = tag;
        exp_q.push_back(e);
    endtask

    // monitor: compare one entry per clock after the register updates
    always @(posedge clk) begin
        #1;
        if (!rst && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, "/R3"}, "invalid", {31'd0, op_invalid_q}, {31'd0, e.inv});
            if (!e.inv) begin
                chk(e.tag, "result", alu_res_q, e.res);
                chk({e.tag, "/R5"}, "zero", {31'd0, zero_q}, {31'd0, e.zero});
            end
            chk({e.tag, "/R7"}, "target", br_target_q, e.bt);
            chk({e.tag, "/R8"}, "dest", {27'd0, dest_reg_q}, {27'd0, e.dest});
            chk({e.tag, "/R9"}, "store", store_val_q, e.store);
            chk({e.tag, "/R9"}, "ctl", {27'd0, wb_ctl_q, mem_ctl_q}, {27'd0, e.wb, e.mem});
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        wb_ctl_in = 2'b11; mem_ctl_in = 3'b101; alu_op_in = 2'b00;
        alu_src_in = 1'b0; reg_dst_in = 1'b1; funct_in = 6'b100000;
        next_pc_in = 32'h40; rd_val_a = 32'h11; rd_val_b = 32'h22;
        imm_ext = 32'h4; rt_field = 5'd3; rd_field = 5'd9;
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk("R10", "result", alu_res_q, 32'd0);
        chk("R10", "zero", {31'd0, zero_q}, 32'd1);
        chk("R10", "target", br_target_q, 32'd0);
        chk("R10", "ctl/dest/inv", {22'd0, wb_ctl_q, mem_ctl_q, dest_reg_q, op_invalid_q}, 32'd0);
        chk("R10", "store", store_val_q, 32'd0);
        rst = 1'b0;

        // R1: add class ignores funct
        drive("R1", 2'b00, 6'b101010, 0, 0, 32'd5, 32'd7, 32'd0, 32'd100, 5'd2, 5'd4, 2'b10, 3'b001);
        // R1/R7: subtract with equal operands plus negative offset in same cycle
        drive("R1", 2'b01, 6'b100100, 0, 1, 32'd9, 32'd9, 32'hFFFF_FFF8, 32'd100, 5'd6, 5'd17, 2'b00, 3'b100);
        drive("R1", 2'b01, 6'b000000, 0, 0, 32'd3, 32'd10, 32'h10, 32'h1000, 5'd31, 5'd0, 2'b01, 3'b010);
        // R2: function decode
        drive("R2", 2'b10, 6'b100000, 0, 1, 32'hFFFF_FFFF, 32'd1, 32'd8, 32'd8, 5'd1, 5'd5, 2'b11, 3'b000);
        drive("R2", 2'b10, 6'b100010, 0, 1, 32'd3, 32'd5, 32'd0, 32'd4, 5'd1, 5'd7, 2'b10, 3'b011);
        drive("R2", 2'b10, 6'b100100, 0, 1, 32'hF0F0_1234, 32'h0FF0_FF00, 32'd0, 32'd0, 5'd2, 5'd8, 2'b01, 3'b111);
        drive("R2", 2'b10, 6'b100101, 0, 1, 32'hA000_0001, 32'h0500_0010, 32'd0, 32'd0, 5'd2, 5'd8, 2'b00, 3'b110);
        // R4: signed set-less-than
        drive("R4", 2'b10, 6'b101010, 0, 1, 32'hFFFF_FFFF, 32'd1, 32'd0, 32'd12, 5'd3, 5'd9, 2'b10, 3'b000);
        drive("R4", 2'b10, 6'b101010, 0, 1, 32'd5, 32'd3, 32'd0, 32'd12, 5'd3, 5'd9, 2'b10, 3'b000);
        drive("R4", 2'b10, 6'b101010, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, 32'd0, 32'd12, 5'd3, 5'd9, 2'b10, 3'b000);
        drive("R4", 2'b10, 6'b101010, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 32'd12, 5'd3, 5'd9, 2'b10, 3'b000);
        // R3: invalid combinations
        drive("R3", 2'b11, 6'b100000, 0, 0, 32'd1, 32'd2, 32'd20, 32'd40, 5'd12, 5'd13, 2'b11, 3'b111);
        drive("R3", 2'b10, 6'b000000, 0, 1, 32'd1, 32'd2, 32'd20, 32'd40, 5'd12, 5'd13, 2'b01, 3'b001);
        // R6: immediate operand path, register value still forwarded for store
        drive("R6", 2'b00, 6'b000000, 1, 0, 32'd10, 32'hDEAD_BEEF, 32'hFFFF_FFFD, 32'h200, 5'd14, 5'd15, 2'b10, 3'b010);
        drive("R6", 2'b10, 6'b100010, 1, 0, 32'd20, 32'd20, 32'd7, 32'h300, 5'd18, 5'd19, 2'b01, 3'b001);
        // R7: target wraps modulo 2^32
        drive("R7", 2'b00, 6'b000000, 0, 1, 32'd0, 32'd0, 32'h0000_0010, 32'hFFFF_FFF8, 5'd20, 5'd21, 2'b00, 3'b000);

        repeat (3) @(posedge clk);
        #2;
        chk("R9", "queue drained", exp_q.size(), 32'd0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule